// File: doc/BRIEF.md
# Core-to-Platform MMIO Bridge

This block connects a processor core to the uncore platform for memory-mapped I/O. On the core side it takes load/store data accesses aimed at MMIO space and instruction fetches aimed at boot ROM. It sends them one at a time over a single core-request channel and hands the platform's answer back to whichever side issued the request. Data accesses win over fetches when both are waiting. A fetch names its superscalar slots with a way mask, and its answer returns one optional instruction per slot.

In the other direction the platform can post the timer-interrupt bit, read the software-interrupt bit or write it. Each of these requests waits until the core reports that no CSR-write or interrupt instruction is in flight. Only then is it applied to the CSR file and answered. While a platform request is held, a pending output tells the rename stage to stop renaming. A separate input lets the platform load a new machine time, which is forwarded to the CSR copy one cycle later. A combinational classifier reports whether a physical address is MMIO: it checks a fixed address window and two programmable host-communication addresses.

Top module: `mmio_bridge`

## Requirements
- R1: After reset no core request is outstanding (`creq_valid`, `drsp_valid`, `frsp_valid` low, `dreq_ready` high), `pending_prq` and `prsp_valid` are low, and both host-communication addresses are zero, so address 0 classifies as MMIO.
- R2: `cls_is_mmio` is high for every address A with `MMIO_BASE <= A < MMIO_LIMIT` and low just outside that window, unless A matches a host address.
- R3: A cycle with `htif_cfg_we` high loads `htif_to_addr` and `htif_from_addr`; from the next cycle on, those two addresses classify as MMIO and the previous ones no longer do.
- R4: Only one core request is outstanding. After a data request is accepted, `dreq_ready` and `freq_ready` stay low until the response has been taken: `drsp_deq` for data, a `frsp_ready` handshake for a fetch.
- R5: When `dreq_valid` and `freq_valid` are both high in an idle cycle, the data request is accepted (`dreq_ready` high, `freq_ready` low) and is issued first with `creq_fetch` low.
- R6: A platform response goes only to the recorded requester. Data answers raise `drsp_valid` with `drsp_data` equal to `crsp_data`. Fetch answers raise `frsp_valid`, set slot i valid exactly when bit i of the request's way mask is set, and take slot i's instruction from `crsp_data[i*INST_W +: INST_W]`.
- R7: Every channel transfers on a cycle with valid and ready both high. `creq_valid` and its payload hold steady until `creq_ready`, and `crsp_ready` is high only while a request awaits its answer.
- R8: A platform request of kind 0 (set timer bit), 1 (read software bit) or 2 (write software bit) causes no CSR write while `no_inflight_csr` is low. It is applied in the first held cycle in which that flag is high.
- R9: After a platform request is applied, `prsp_valid` rises on the next cycle. A read answers with `prsp_is_read` high and `prsp_bit` equal to the software bit sampled when it was applied. A write or timer request answers with `prsp_is_read` low and `prsp_bit` 0.
- R10: `pending_prq` is high from the cycle after a platform request is accepted until the cycle after its response handshake. `preq_ready` is low throughout.
- R11: A cycle with `plat_time_we` high yields, one cycle later, `csr_time_we` high with `csr_time_val` equal to the value that was written.
- R12: Applying a kind-0 request pulses `csr_mtip_we` for one cycle with `csr_mtip_val` equal to the request bit. Applying a kind-2 request pulses `csr_msip_we` with `csr_msip_val` equal to the request bit. A read writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_addr | input | ADDR_W | Physical address to classify |
| cls_is_mmio | output | 1 | Address is MMIO |
| htif_cfg_we | input | 1 | Load host-communication addresses |
| htif_to_addr | input | ADDR_W | To-host address |
| htif_from_addr | input | ADDR_W | From-host address |
| dreq_valid | input | 1 | Data request valid |
| dreq_ready | output | 1 | Data request accepted |
| dreq_addr | input | ADDR_W | Data request address |
| dreq_write | input | 1 | Data request is a store |
| dreq_wdata | input | DATA_W | Store data |
| drsp_valid | output | 1 | Data response available |
| drsp_data | output | DATA_W | Data response payload |
| drsp_deq | input | 1 | Dequeue data response |
| freq_valid | input | 1 | Fetch request valid |
| freq_ready | output | 1 | Fetch request accepted |
| freq_addr | input | ADDR_W | Fetch address |
| freq_way | input | WAYS | Fetch way mask |
| frsp_valid | output | 1 | Fetch response valid |
| frsp_ready | input | 1 | Fetch response taken |
| frsp_slot_valid | output | WAYS | Per-slot instruction present |
| frsp_inst | output | WAYS*INST_W | Per-slot instructions |
| creq_valid | output | 1 | Core request to platform valid |
| creq_ready | input | 1 | Platform accepts core request |
| creq_addr | output | ADDR_W | Core request address |
| creq_write | output | 1 | Core request is a store |
| creq_wdata | output | DATA_W | Core request store data |
| creq_fetch | output | 1 | Core request is a fetch |
| creq_way | output | WAYS | Fetch way mask |
| crsp_valid | input | 1 | Platform response valid |
| crsp_ready | output | 1 | Bridge accepts platform response |
| crsp_data | input | DATA_W | Platform response payload |
| preq_valid | input | 1 | Platform request valid |
| preq_ready | output | 1 | Bridge accepts platform request |
| preq_kind | input | 2 | 0 set timer bit, 1 read soft bit, 2 write soft bit |
| preq_bit | input | 1 | Bit value for set/write |
| prsp_valid | output | 1 | Response to platform valid |
| prsp_ready | input | 1 | Platform takes response |
| prsp_is_read | output | 1 | Response answers a read |
| prsp_bit | output | 1 | Read value (0 for writes) |
| no_inflight_csr | input | 1 | No CSR-write or interrupt instruction in flight |
| csr_msip_in | input | 1 | Current software-interrupt bit |
| csr_msip_we | output | 1 | Write software-interrupt bit |
| csr_msip_val | output | 1 | New software-interrupt bit |
| csr_mtip_we | output | 1 | Write timer-interrupt bit |
| csr_mtip_val | output | 1 | New timer-interrupt bit |
| plat_time_we | input | 1 | Platform writes machine time |
| plat_time_val | input | DATA_W | New machine time |
| csr_time_we | output | 1 | Update CSR time copy |
| csr_time_val | output | DATA_W | Time value for CSR copy |
| pending_prq | output | 1 | Platform request held; stall rename |

## Verification
The properties assume that the platform raises `crsp_valid` only for a request it has accepted, and that the core raises `drsp_deq` or `frsp_ready` only while the matching response is offered. The stability property on the core-request channel also assumes the platform does not drop a request it has not yet taken. The bench stays within these limits. It plays both ends of every channel by hand, raising a response only after it has seen the request handshake and acknowledging only a response it can see. It holds `no_inflight_csr` low for several cycles before releasing it, so that platform requests are actually held.

// File: rtl/mmio_bridge_pkg.sv
package mmio_bridge_pkg;

    // Platform request kinds (encoding visible on preq_kind)
    typedef enum logic [1:0] {
        PK_SET_TIMER  = 2'd0,
        PK_READ_SOFT  = 2'd1,
        PK_WRITE_SOFT = 2'd2,
        PK_NOP        = 2'd3
    } plat_kind_e;

    // Core-side request tracker
    typedef enum logic [2:0] {
        CS_IDLE       = 3'd0,
        CS_ISSUE      = 3'd1,
        CS_WAIT       = 3'd2,
        CS_DATA_HOLD  = 3'd3,
        CS_FETCH_HOLD = 3'd4
    } core_state_e;

    // Platform-side request tracker
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_HOLD = 2'd1,
        PS_RESP = 2'd2
    } plat_state_e;

    function automatic logic kind_writes_csr(input plat_kind_e k);
        return (k == PK_SET_TIMER) || (k == PK_WRITE_SOFT);
    endfunction

endpackage

// File: rtl/mmio_addr_classifier.sv
module mmio_addr_classifier #(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] MMIO_BASE  = 32'h1000_0000,
    parameter logic [31:0] MMIO_LIMIT = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_to,
    input  logic [ADDR_W-1:0] cfg_from,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_mmio
);
    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(MMIO_BASE);
    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(MMIO_LIMIT);

    logic [ADDR_W-1:0] to_q, from_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            to_q   <= '0;
            from_q <= '0;
        end else if (cfg_we) begin
            to_q   <= cfg_to;
            from_q <= cfg_from;
        end
    end

    logic in_window;
    always_comb begin
        in_window = (addr >= BASE_A) && (addr < LIMIT_A);
        is_mmio   = in_window || (addr == to_q) || (addr == from_q);
    end
endmodule

// File: rtl/mmio_core_port.sv
module mmio_core_port
    import mmio_bridge_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int WAYS   = 2,
    parameter int INST_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   dreq_valid,
    output logic                   dreq_ready,
    input  logic [ADDR_W-1:0]      dreq_addr,
    input  logic                   dreq_write,
    input  logic [DATA_W-1:0]      dreq_wdata,
    output logic                   drsp_valid,
    output logic [DATA_W-1:0]      drsp_data,
    input  logic                   drsp_deq,
    input  logic                   freq_valid,
    output logic                   freq_ready,
    input  logic [ADDR_W-1:0]      freq_addr,
    input  logic [WAYS-1:0]        freq_way,
    output logic                   frsp_valid,
    input  logic                   frsp_ready,
    output logic [WAYS-1:0]        frsp_slot_valid,
    output logic [WAYS*INST_W-1:0] frsp_inst,
    output logic                   creq_valid,
    input  logic                   creq_ready,
    output logic [ADDR_W-1:0]      creq_addr,
    output logic                   creq_write,
    output logic [DATA_W-1:0]      creq_wdata,
    output logic                   creq_fetch,
    output logic [WAYS-1:0]        creq_way,
    input  logic                   crsp_valid,
    output logic                   crsp_ready,
    input  logic [DATA_W-1:0]      crsp_data
);
    // A fetch answer packs one instruction per slot into the data word
    localparam int SLOT_BITS = WAYS * INST_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic              fetch;
        logic [WAYS-1:0]   way;
    } core_req_t;

    core_state_e       st_q;
    core_req_t         req_q;
    logic [DATA_W-1:0] rsp_q;

    logic take_data, take_fetch;

    always_comb begin
        // Data requests take precedence over fetches for the single slot
        dreq_ready = (st_q == CS_IDLE);
        freq_ready = (st_q == CS_IDLE) && !dreq_valid;
        take_data  = dreq_valid && dreq_ready;
        take_fetch = freq_valid && freq_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CS_IDLE;
            req_q <= '0;
            rsp_q <= '0;
        end else begin
            unique case (st_q)
                CS_IDLE: begin
                    if (take_data) begin
                        req_q <= '{addr: dreq_addr, write: dreq_write, wdata: dreq_wdata,
                                   fetch: 1'b0, way: '0};
                        st_q  <= CS_ISSUE;
                    end else if (take_fetch) begin
                        req_q <= '{addr: freq_addr, write: 1'b0, wdata: '0,
                                   fetch: 1'b1, way: freq_way};
                        st_q  <= CS_ISSUE;
                    end
                end
                CS_ISSUE: if (creq_ready) st_q <= CS_WAIT;
                CS_WAIT: begin
                    if (crsp_valid) begin
                        rsp_q <= crsp_data;
                        st_q  <= req_q.fetch ? CS_FETCH_HOLD : CS_DATA_HOLD;
                    end
                end
                CS_DATA_HOLD:  if (drsp_deq)   st_q <= CS_IDLE;
                CS_FETCH_HOLD: if (frsp_ready) st_q <= CS_IDLE;
                default: st_q <= CS_IDLE;
            endcase
        end
    end

    always_comb begin
        creq_valid = (st_q == CS_ISSUE);
        creq_addr  = req_q.addr;
        creq_write = req_q.write;
        creq_wdata = req_q.wdata;
        creq_fetch = req_q.fetch;
        creq_way   = req_q.way;
        crsp_ready = (st_q == CS_WAIT);
        drsp_valid = (st_q == CS_DATA_HOLD);
        drsp_data  = rsp_q;
        frsp_valid = (st_q == CS_FETCH_HOLD);
    end

    // Unpack the fetch answer into per-way optional instructions
    for (genvar i = 0; i < WAYS; i++) begin : g_slot
        assign frsp_slot_valid[i]             = req_q.way[i];
        assign frsp_inst[i*INST_W +: INST_W]  = rsp_q[i*INST_W +: INST_W];
    end

    if (SLOT_BITS > DATA_W) begin : g_bad_width
        initial $display("mmio_core_port: WAYS*INST_W exceeds DATA_W");
    end
endmodule

// File: rtl/mmio_plat_port.sv
module mmio_plat_port
    import mmio_bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       preq_valid,
    output logic       preq_ready,
    input  logic [1:0] preq_kind,
    input  logic       preq_bit,
    output logic       prsp_valid,
    input  logic       prsp_ready,
    output logic       prsp_is_read,
    output logic       prsp_bit,
    input  logic       no_inflight_csr,
    input  logic       csr_msip_in,
    output logic       csr_msip_we,
    output logic       csr_msip_val,
    output logic       csr_mtip_we,
    output logic       csr_mtip_val,
    output logic       pending
);
    plat_state_e st_q;
    plat_kind_e  kind_q;
    logic        bit_q;
    logic        rd_q;
    logic        apply;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PS_IDLE;
            kind_q <= PK_NOP;
            bit_q  <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            unique case (st_q)
                PS_IDLE: begin
                    if (preq_valid) begin
                        kind_q <= plat_kind_e'(preq_kind);
                        bit_q  <= preq_bit;
                        st_q   <= PS_HOLD;
                    end
                end
                PS_HOLD: begin
                    if (apply) begin
                        rd_q <= (kind_q == PK_READ_SOFT) ? csr_msip_in : 1'b0;
                        st_q <= PS_RESP;
                    end
                end
                PS_RESP: if (prsp_ready) st_q <= PS_IDLE;
                default: st_q <= PS_IDLE;
            endcase
        end
    end

    always_comb begin
        preq_ready   = (st_q == PS_IDLE);
        // Held until the core has no CSR-write or interrupt instruction in flight
        apply        = (st_q == PS_HOLD) && no_inflight_csr;
        csr_msip_we  = apply && kind_writes_csr(kind_q) && (kind_q == PK_WRITE_SOFT);
        csr_mtip_we  = apply && (kind_q == PK_SET_TIMER);
        csr_msip_val = bit_q;
        csr_mtip_val = bit_q;
        prsp_valid   = (st_q == PS_RESP);
        prsp_is_read = (kind_q == PK_READ_SOFT);
        prsp_bit     = rd_q;
        pending      = (st_q != PS_IDLE);
    end
endmodule

// File: rtl/mmio_bridge.sv
module mmio_bridge
    import mmio_bridge_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 64,
    parameter int          WAYS       = 2,
    parameter int          INST_W     = 32,
    parameter logic [31:0] MMIO_BASE  = 32'h1000_0000,
    parameter logic [31:0] MMIO_LIMIT = 32'h2000_0000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      cls_addr,
    output logic                   cls_is_mmio,
    input  logic                   htif_cfg_we,
    input  logic [ADDR_W-1:0]      htif_to_addr,
    input  logic [ADDR_W-1:0]      htif_from_addr,
    input  logic                   dreq_valid,
    output logic                   dreq_ready,
    input  logic [ADDR_W-1:0]      dreq_addr,
    input  logic                   dreq_write,
    input  logic [DATA_W-1:0]      dreq_wdata,
    output logic                   drsp_valid,
    output logic [DATA_W-1:0]      drsp_data,
    input  logic                   drsp_deq,
    input  logic                   freq_valid,
    output logic                   freq_ready,
    input  logic [ADDR_W-1:0]      freq_addr,
    input  logic [WAYS-1:0]        freq_way,
    output logic                   frsp_valid,
    input  logic                   frsp_ready,
    output logic [WAYS-1:0]        frsp_slot_valid,
    output logic [WAYS*INST_W-1:0] frsp_inst,
    output logic                   creq_valid,
    input  logic                   creq_ready,
    output logic [ADDR_W-1:0]      creq_addr,
    output logic                   creq_write,
    output logic [DATA_W-1:0]      creq_wdata,
    output logic                   creq_fetch,
    output logic [WAYS-1:0]        creq_way,
    input  logic                   crsp_valid,
    output logic                   crsp_ready,
    input  logic [DATA_W-1:0]      crsp_data,
    input  logic                   preq_valid,
    output logic                   preq_ready,
    input  logic [1:0]             preq_kind,
    input  logic                   preq_bit,
    output logic                   prsp_valid,
    input  logic                   prsp_ready,
    output logic                   prsp_is_read,
    output logic                   prsp_bit,
    input  logic                   no_inflight_csr,
    input  logic                   csr_msip_in,
    output logic                   csr_msip_we,
    output logic                   csr_msip_val,
    output logic                   csr_mtip_we,
    output logic                   csr_mtip_val,
    input  logic                   plat_time_we,
    input  logic [DATA_W-1:0]      plat_time_val,
    output logic                   csr_time_we,
    output logic [DATA_W-1:0]      csr_time_val,
    output logic                   pending_prq
);

    mmio_addr_classifier #(
        .ADDR_W(ADDR_W), .MMIO_BASE(MMIO_BASE), .MMIO_LIMIT(MMIO_LIMIT)
    ) u_cls (
        .clk(clk), .rst(rst),
        .cfg_we(htif_cfg_we), .cfg_to(htif_to_addr), .cfg_from(htif_from_addr),
        .addr(cls_addr), .is_mmio(cls_is_mmio)
    );

    mmio_core_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .INST_W(INST_W)
    ) u_core (
        .clk(clk), .rst(rst),
        .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_addr(dreq_addr),
        .dreq_write(dreq_write), .dreq_wdata(dreq_wdata),
        .drsp_valid(drsp_valid), .drsp_data(drsp_data), .drsp_deq(drsp_deq),
        .freq_valid(freq_valid), .freq_ready(freq_ready), .freq_addr(freq_addr),
        .freq_way(freq_way),
        .frsp_valid(frsp_valid), .frsp_ready(frsp_ready),
        .frsp_slot_valid(frsp_slot_valid), .frsp_inst(frsp_inst),
        .creq_valid(creq_valid), .creq_ready(creq_ready), .creq_addr(creq_addr),
        .creq_write(creq_write), .creq_wdata(creq_wdata), .creq_fetch(creq_fetch),
        .creq_way(creq_way),
        .crsp_valid(crsp_valid), .crsp_ready(crsp_ready), .crsp_data(crsp_data)
    );

    mmio_plat_port u_plat (
        .clk(clk), .rst(rst),
        .preq_valid(preq_valid), .preq_ready(preq_ready),
        .preq_kind(preq_kind), .preq_bit(preq_bit),
        .prsp_valid(prsp_valid), .prsp_ready(prsp_ready),
        .prsp_is_read(prsp_is_read), .prsp_bit(prsp_bit),
        .no_inflight_csr(no_inflight_csr), .csr_msip_in(csr_msip_in),
        .csr_msip_we(csr_msip_we), .csr_msip_val(csr_msip_val),
        .csr_mtip_we(csr_mtip_we), .csr_mtip_val(csr_mtip_val),
        .pending(pending_prq)
    );

    // Machine-time update forwarded to the CSR copy one cycle later
    always_ff @(posedge clk) begin
        if (rst) begin
            csr_time_we  <= 1'b0;
            csr_time_val <= '0;
        end else begin
            csr_time_we <= plat_time_we;
            if (plat_time_we) csr_time_val <= plat_time_val;
        end
    end
endmodule

// File: rtl/mmio_bridge_chk.sv
module mmio_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              dreq_valid,
    input logic              dreq_ready,
    input logic              freq_ready,
    input logic              drsp_valid,
    input logic              drsp_deq,
    input logic              creq_valid,
    input logic              creq_ready,
    input logic [ADDR_W-1:0] creq_addr,
    input logic              creq_fetch,
    input logic              csr_msip_we,
    input logic              csr_mtip_we,
    input logic              no_inflight_csr,
    input logic              preq_valid,
    input logic              preq_ready,
    input logic              prsp_valid,
    input logic              prsp_ready,
    input logic              pending_prq,
    input logic              plat_time_we,
    input logic [DATA_W-1:0] plat_time_val,
    input logic              csr_time_we,
    input logic [DATA_W-1:0] csr_time_val
);
    AST_DATA_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (dreq_valid && dreq_ready) |=> !dreq_ready && !freq_ready); // R4
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (drsp_valid && !drsp_deq) |=> drsp_valid && !dreq_ready); // R4
    AST_DATA_FIRST: assert property (@(posedge clk) disable iff (rst)
        (dreq_valid && dreq_ready) |-> !freq_ready); // R5
    AST_CREQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (creq_valid && !creq_ready) |=> creq_valid && $stable(creq_addr) && $stable(creq_fetch)); // R7
    AST_CSR_GATED: assert property (@(posedge clk) disable iff (rst)
        (csr_msip_we || csr_mtip_we) |-> no_inflight_csr); // R8
    AST_RESP_PENDING: assert property (@(posedge clk) disable iff (rst)
        prsp_valid |-> pending_prq); // R9
    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        (preq_valid && preq_ready) |=> pending_prq && !preq_ready); // R10
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (prsp_valid && prsp_ready) |=> !pending_prq); // R10
    AST_TIME_FWD: assert property (@(posedge clk) disable iff (rst)
        plat_time_we |=> csr_time_we && (csr_time_val == $past(plat_time_val))); // R11
endmodule

bind mmio_bridge mmio_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .freq_ready(freq_ready),
    .drsp_valid(drsp_valid), .drsp_deq(drsp_deq),
    .creq_valid(creq_valid), .creq_ready(creq_ready), .creq_addr(creq_addr),
    .creq_fetch(creq_fetch),
    .csr_msip_we(csr_msip_we), .csr_mtip_we(csr_mtip_we), .no_inflight_csr(no_inflight_csr),
    .preq_valid(preq_valid), .preq_ready(preq_ready),
    .prsp_valid(prsp_valid), .prsp_ready(prsp_ready), .pending_prq(pending_prq),
    .plat_time_we(plat_time_we), .plat_time_val(plat_time_val),
    .csr_time_we(csr_time_we), .csr_time_val(csr_time_val)
);

// File: tb/test_mmio_bridge.sv
`timescale 1ns/1ps
module test_mmio_bridge;
    localparam int AW = 32, DW = 64, WY = 2, IW = 32;

    logic clk = 1'b0, rst = 1'b1;
    always #10 clk = ~clk;

    logic [AW-1:0] cls_addr = '0;
    logic cls_is_mmio;
    logic htif_cfg_we = 0;
    logic [AW-1:0] htif_to_addr = '0, htif_from_addr = '0;
    logic dreq_valid = 0, dreq_ready, dreq_write = 0;
    logic [AW-1:0] dreq_addr = '0;
    logic [DW-1:0] dreq_wdata = '0;
    logic drsp_valid, drsp_deq = 0;
    logic [DW-1:0] drsp_data;
    logic freq_valid = 0, freq_ready;
    logic [AW-1:0] freq_addr = '0;
    logic [WY-1:0] freq_way = '0;
    logic frsp_valid, frsp_ready = 0;
    logic [WY-1:0] frsp_slot_valid;
    logic [WY*IW-1:0] frsp_inst;
    logic creq_valid, creq_ready = 0, creq_write, creq_fetch;
    logic [AW-1:0] creq_addr;
    logic [DW-1:0] creq_wdata;
    logic [WY-1:0] creq_way;
    logic crsp_valid = 0, crsp_ready;
    logic [DW-1:0] crsp_data = '0;
    logic preq_valid = 0, preq_ready, preq_bit = 0;
    logic [1:0] preq_kind = 2'd3;
    logic prsp_valid, prsp_ready = 0, prsp_is_read, prsp_bit;
    logic no_inflight_csr = 0, csr_msip_in = 0;
    logic csr_msip_we, csr_msip_val, csr_mtip_we, csr_mtip_val;
    logic plat_time_we = 0;
    logic [DW-1:0] plat_time_val = '0;
    logic csr_time_we;
    logic [DW-1:0] csr_time_val;
    logic pending_prq;

    mmio_bridge #(.ADDR_W(AW), .DATA_W(DW), .WAYS(WY), .INST_W(IW)) i_mmio_bridge (.*);

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Platform side of the core-request channel: take the request, then answer
    task automatic serve(input logic [DW-1:0] d);
        creq_ready = 1;
        @(negedge clk);
        creq_ready = 0;
        crsp_valid = 1; crsp_data = d;
        #1 chk("R7 crsp_ready while waiting", crsp_ready, 1);
        @(negedge clk);
        crsp_valid = 0;
        #1;
    endtask

    task automatic t_reset;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #1;
        chk("R1 creq_valid", creq_valid, 0);
        chk("R1 drsp_valid", drsp_valid, 0);
        chk("R1 frsp_valid", frsp_valid, 0);
        chk("R1 dreq_ready", dreq_ready, 1);
        chk("R1 pending_prq", pending_prq, 0);
        chk("R1 prsp_valid", prsp_valid, 0);
        cls_addr = 32'h0; #1 chk("R1 addr0 is host default", cls_is_mmio, 1);
    endtask

    task automatic t_classify;
        cls_addr = 32'h1000_0000; #1 chk("R2 base", cls_is_mmio, 1);
        cls_addr = 32'h1FFF_FFFF; #1 chk("R2 limit-1", cls_is_mmio, 1);
        cls_addr = 32'h2000_0000; #1 chk("R2 limit", cls_is_mmio, 0);
        cls_addr = 32'h0FFF_FFFF; #1 chk("R2 base-1", cls_is_mmio, 0);
        @(negedge clk);
        htif_cfg_we = 1; htif_to_addr = 32'h8000_1000; htif_from_addr = 32'h8000_1040;
        @(negedge clk);
        htif_cfg_we = 0;
        cls_addr = 32'h8000_1000; #1 chk("R3 to-host", cls_is_mmio, 1);
        cls_addr = 32'h8000_1040; #1 chk("R3 from-host", cls_is_mmio, 1);
        cls_addr = 32'h8000_1008; #1 chk("R3 neighbour", cls_is_mmio, 0);
        cls_addr = 32'h0;         #1 chk("R3 old zero dropped", cls_is_mmio, 0);
    endtask

    task automatic t_data;
        @(negedge clk);
        dreq_valid = 1; dreq_addr = 32'h1000_0040; dreq_write = 1; dreq_wdata = 64'hDEAD_BEEF_0123_4567;
        #1 chk("R4 ready when idle", dreq_ready, 1);
        @(negedge clk);
        dreq_valid = 0;
        #1;
        chk("R7 creq_valid", creq_valid, 1);
        chk("R7 creq_addr", creq_addr, 32'h1000_0040);
        chk("R7 creq_wdata", creq_wdata, 64'hDEAD_BEEF_0123_4567);
        chk("R7 creq_write", creq_write, 1);
        chk("R7 crsp_ready before issue", crsp_ready, 0);
        @(negedge clk); #1;
        chk("R7 held while not ready", creq_valid, 1);
        chk("R7 addr stable", creq_addr, 32'h1000_0040);
        creq_ready = 1;
        @(negedge clk);
        creq_ready = 0;
        dreq_valid = 1; dreq_addr = 32'h1000_0080; dreq_write = 0;
        #1;
        chk("R7 creq dropped after handshake", creq_valid, 0);
        chk("R4 second request refused", dreq_ready, 0);
        crsp_valid = 1; crsp_data = 64'h1111_2222_3333_4444;
        @(negedge clk);
        crsp_valid = 0;
        #1;
        chk("R6 drsp_valid", drsp_valid, 1);
        chk("R6 drsp_data", drsp_data, 64'h1111_2222_3333_4444);
        chk("R6 no fetch response", frsp_valid, 0);
        chk("R4 refused until dequeue", dreq_ready, 0);
        @(negedge clk); #1;
        chk("R4 response held", drsp_valid, 1);
        drsp_deq = 1;
        @(negedge clk);
        drsp_deq = 0;
        #1 chk("R4 ready after dequeue", dreq_ready, 1);
        // the waiting second request is now accepted; finish it
        @(negedge clk);
        dreq_valid = 0;
        #1 chk("R7 second addr", creq_addr, 32'h1000_0080);
        serve(64'h5);
        chk("R6 second data", drsp_data, 64'h5);
        drsp_deq = 1;
        @(negedge clk);
        drsp_deq = 0;
    endtask

    task automatic t_priority;
        @(negedge clk);
        dreq_valid = 1; dreq_addr = 32'h1000_0100; dreq_write = 0;
        freq_valid = 1; freq_addr = 32'h0000_1000; freq_way = 2'b10;
        #1;
        chk("R5 data accepted", dreq_ready, 1);
        chk("R5 fetch waits", freq_ready, 0);
        @(negedge clk);
        dreq_valid = 0;
        #1;
        chk("R5 data issued first", creq_fetch, 0);
        chk("R5 data addr", creq_addr, 32'h1000_0100);
        chk("R4 fetch blocked while busy", freq_ready, 0);
        serve(64'hABCD);
        chk("R6 data answer to data side", drsp_valid, 1);
        chk("R6 no fetch answer", frsp_valid, 0);
        drsp_deq = 1;
        @(negedge clk);
        drsp_deq = 0;
        #1 chk("R5 fetch accepted once idle", freq_ready, 1);
        @(negedge clk);
        freq_valid = 0;
        #1;
        chk("R6 fetch issued", creq_fetch, 1);
        chk("R6 fetch addr", creq_addr, 32'h0000_1000);
        chk("R6 fetch way", creq_way, 2'b10);
        serve({32'hBBBB_0002, 32'hAAAA_0001});
        chk("R6 frsp_valid", frsp_valid, 1);
        chk("R6 no data answer", drsp_valid, 0);
        chk("R6 slot mask", frsp_slot_valid, 2'b10);
        chk("R6 slot contents", frsp_inst, {32'hBBBB_0002, 32'hAAAA_0001});
        @(negedge clk); #1;
        chk("R4 fetch answer held", frsp_valid, 1);
        chk("R4 data blocked during fetch answer", dreq_ready, 0);
        frsp_ready = 1;
        @(negedge clk);
        frsp_ready = 0;
        #1;
        chk("R4 idle after fetch", dreq_ready, 1);
        chk("R4 fetch answer gone", frsp_valid, 0);
    endtask

    task automatic ack_plat;
        prsp_ready = 1;
        @(negedge clk);
        prsp_ready = 0;
        #1;
        chk("R10 pending cleared", pending_prq, 0);
        chk("R10 ready again", preq_ready, 1);
    endtask

    task automatic t_plat_write_held;
        @(negedge clk);
        no_inflight_csr = 0;
        preq_valid = 1; preq_kind = 2'd2; preq_bit = 1;
        #1;
        chk("R10 accepts", preq_ready, 1);
        chk("R10 not yet pending", pending_prq, 0);
        @(negedge clk);
        preq_valid = 0;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R8 no write while in flight", csr_msip_we, 0);
            chk("R8 no timer write", csr_mtip_we, 0);
            chk("R10 pending", pending_prq, 1);
            chk("R9 no response yet", prsp_valid, 0);
            @(negedge clk);
        end
        no_inflight_csr = 1;
        #1;
        chk("R12 soft write applied", csr_msip_we, 1);
        chk("R12 soft value", csr_msip_val, 1);
        @(negedge clk); #1;
        chk("R12 single pulse", csr_msip_we, 0);
        chk("R9 response valid", prsp_valid, 1);
        chk("R9 write ack", prsp_is_read, 0);
        chk("R9 write no data", prsp_bit, 0);
        chk("R10 pending until ack", pending_prq, 1);
        ack_plat();
    endtask

    task automatic t_plat_read;
        @(negedge clk);
        csr_msip_in = 1; no_inflight_csr = 1;
        preq_valid = 1; preq_kind = 2'd1; preq_bit = 0;
        @(negedge clk);
        preq_valid = 0;
        #1;
        chk("R12 read writes no soft bit", csr_msip_we, 0);
        chk("R12 read writes no timer bit", csr_mtip_we, 0);
        @(negedge clk);
        csr_msip_in = 0;
        #1;
        chk("R9 read response", prsp_valid, 1);
        chk("R9 read flag", prsp_is_read, 1);
        chk("R9 read value sampled", prsp_bit, 1);
        ack_plat();
    endtask

    task automatic t_timer;
        @(negedge clk);
        no_inflight_csr = 1;
        preq_valid = 1; preq_kind = 2'd0; preq_bit = 1;
        @(negedge clk);
        preq_valid = 0;
        #1;
        chk("R12 timer write", csr_mtip_we, 1);
        chk("R12 timer value", csr_mtip_val, 1);
        chk("R12 no soft write", csr_msip_we, 0);
        @(negedge clk); #1;
        chk("R9 timer ack", prsp_valid, 1);
        chk("R9 timer not read", prsp_is_read, 0);
        ack_plat();
    endtask

    task automatic t_time;
        @(negedge clk);
        plat_time_we = 1; plat_time_val = 64'h0000_0123_4567_89AB;
        #1 chk("R11 not yet forwarded", csr_time_we, 0);
        @(negedge clk);
        plat_time_we = 0;
        #1;
        chk("R11 forwarded", csr_time_we, 1);
        chk("R11 value", csr_time_val, 64'h0000_0123_4567_89AB);
        @(negedge clk); #1;
        chk("R11 single pulse", csr_time_we, 0);
    endtask

    initial begin
        t_reset();
        t_classify();
        t_data();
        t_priority();
        t_plat_write_held();
        t_plat_read();
        t_timer();
        t_time();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule